// File: doc/BRIEF.md
# SPI Addressed GPIO Expander

This block is an SPI slave that gives a host two 8-bit general-purpose I/O ports through a small register file. The host frames each access with an active-low chip select. It first sends a control byte that names the device and says whether the access is a read or a write. A register-address byte follows, then one or more data bytes. While chip select stays low, the register address steps forward after every data byte, so a burst covers neighbouring registers.

Each port has three registers: a direction register, where a bit of 1 makes the pin an input, a pull-up enable register, and an output latch. A port-value register reads back the live pin state. A configuration register holds an address-enable bit. When that bit is set, the control byte must also carry the value on the three strap pins. The SPI pins are oversampled by the system clock and run in mode 0, MSB first.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset every pin of both ports is an input, so `pa_oe` and `pb_oe` are 0. The latches and pull-up enables read 0 and `miso_oe` is low.
- R2: A control byte selects the device only when its upper nibble is 4'b0100. Bit 0 is the read flag (1 = read). Any other nibble leaves `miso_oe` low and blocks every write until chip select rises.
- R3: While configuration bit 3 (address enable, register 0x08) is 0, control-byte bits 3:1 are ignored.
- R4: While configuration bit 3 is 1, control-byte bits 3:1 must equal `strap`. On a mismatch the device stays deselected and ignores writes.
- R5: Registers 0x00 and 0x01 hold the direction of port A and port B. A bit of 1 is an input and a bit of 0 is an output, so `pX_oe` is the inverse of the direction register.
- R6: Registers 0x02 and 0x03 hold the pull-up enables of A and B and appear on `pa_pu` and `pb_pu`.
- R7: A read of the port-value registers (0x04 for A, 0x05 for B) returns the pad input for input pins and the output latch for output pins.
- R8: A write to the port-value register or to the latch register (0x06 for A, 0x07 for B) loads that port's output latch, which drives `pX_out`.
- R9: After each data byte the register address increments while chip select stays low.
- R10: Raising chip select ends the access. A partly shifted byte is dropped, and the next access starts with a new control byte.
- R11: Read data is shifted out MSB first on `miso`, SPI mode 0, starting with the byte that follows the register-address byte.
- R12: Addresses above 0x08 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | SPI clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for `miso`; when low the line is left floating |
| strap | input | 3 | Hardware address strap pins |
| pa_in | input | 8 | Port A pad inputs |
| pb_in | input | 8 | Port B pad inputs |
| pa_out | output | 8 | Port A output latch |
| pb_out | output | 8 | Port B output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_oe | output | 8 | Port B output enables |
| pa_pu | output | 8 | Port A pull-up enables |
| pb_pu | output | 8 | Port B pull-up enables |

## Verification
Four behaviours are checked by assertions on every cycle:
- the post-reset input state of both ports;
- the release of `miso` after chip select has been high for a few cycles;
- that no port output or enable changes while chip select is inactive;
- that `miso` is driven only inside a chip-select window.

The rest needs the bench's scenarios. These cover decoding of the control byte with the address-enable bit set and clear, and the register map. They also cover the read mux that mixes pad and latch bits, auto-increment across bursts, the dropping of a partial byte, and the value read from an unmapped address.

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander #(
  parameter logic [3:0] DEV_ID = 4'b0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic [2:0] strap,
  input  logic [7:0] pa_in,
  input  logic [7:0] pb_in,
  output logic [7:0] pa_out,
  output logic [7:0] pb_out,
  output logic [7:0] pa_oe,
  output logic [7:0] pb_oe,
  output logic [7:0] pa_pu,
  output logic [7:0] pb_pu
);
  localparam logic [7:0] A_DIRA = 8'h00, A_DIRB = 8'h01, A_PUA = 8'h02, A_PUB = 8'h03,
                         A_VALA = 8'h04, A_VALB = 8'h05, A_LATA = 8'h06, A_LATB = 8'h07,
                         A_CFG  = 8'h08;
  localparam int HAEN_BIT = 3;

  typedef enum logic [1:0] {PH_CTRL, PH_ADDR, PH_DATA} phase_t;

  logic [2:0] sck_q, cs_q, mosi_q;
  logic [7:0] dir_a, dir_b, pu_a, pu_b, lat_a, lat_b, cfg;
  logic [7:0] addr, tx;
  logic [6:0] rx;
  logic [2:0] cnt;
  logic       sel, rw, miso_q;
  phase_t     phase;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire cs_act   = ~cs_q[1];
  wire [7:0] byte_in = {rx, mosi_q[1]};
  wire id_ok    = byte_in[7:4] == DEV_ID;
  wire strap_ok = !cfg[HAEN_BIT] || (byte_in[3:1] == strap);

  function automatic logic [7:0] rd(input logic [7:0] a);
    case (a)
      A_DIRA: rd = dir_a;
      A_DIRB: rd = dir_b;
      A_PUA:  rd = pu_a;
      A_PUB:  rd = pu_b;
      A_VALA: rd = (pa_in & dir_a) | (lat_a & ~dir_a);
      A_VALB: rd = (pb_in & dir_b) | (lat_b & ~dir_b);
      A_LATA: rd = lat_a;
      A_LATB: rd = lat_b;
      A_CFG:  rd = cfg;
      default: rd = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0; cs_q <= '1; mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[1:0], cs_n};
      mosi_q <= {mosi_q[1:0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_a <= 8'hFF; dir_b <= 8'hFF;
      pu_a <= '0; pu_b <= '0; lat_a <= '0; lat_b <= '0; cfg <= '0;
      addr <= '0; tx <= '0; rx <= '0; cnt <= '0;
      sel <= 1'b0; rw <= 1'b0; miso_q <= 1'b0; phase <= PH_CTRL;
    end else if (!cs_act) begin
      phase <= PH_CTRL; cnt <= '0; sel <= 1'b0; rw <= 1'b0; miso_q <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx  <= byte_in[6:0];
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) begin
          case (phase)
            PH_CTRL: begin
              sel   <= id_ok && strap_ok;
              rw    <= byte_in[0];
              phase <= PH_ADDR;
            end
            PH_ADDR: begin
              addr  <= byte_in;
              tx    <= rd(byte_in);
              phase <= PH_DATA;
            end
            default: begin
              if (sel && !rw) begin
                case (addr)
                  A_DIRA: dir_a <= byte_in;
                  A_DIRB: dir_b <= byte_in;
                  A_PUA:  pu_a  <= byte_in;
                  A_PUB:  pu_b  <= byte_in;
                  A_VALA, A_LATA: lat_a <= byte_in;
                  A_VALB, A_LATB: lat_b <= byte_in;
                  A_CFG:  cfg   <= byte_in;
                  default: ;
                endcase
              end
              addr <= addr + 8'd1;
              tx   <= rd(addr + 8'd1);
            end
          endcase
        end
      end
      if (sck_fall && phase == PH_DATA && sel && rw) begin
        miso_q <= tx[7];
        tx     <= {tx[6:0], 1'b0};
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = cs_act & sel & rw;
  assign pa_out  = lat_a;
  assign pb_out  = lat_b;
  assign pa_oe   = ~dir_a;
  assign pb_oe   = ~dir_b;
  assign pa_pu   = pu_a;
  assign pb_pu   = pu_b;
endmodule

// File: rtl/spi_gpio_expander_chk.sv
module spi_gpio_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       miso_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe
);
  // R1
  reset_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && !miso_oe));

  // R10
  release_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe)));

  // R2
  drive_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> !cs_n);
endmodule

bind spi_gpio_expander spi_gpio_expander_chk chk_i (.*);

// File: tb/spi_gpio_expander_tb_top.sv
module spi_gpio_expander_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [2:0] strap = 3'b101;
  logic [7:0] pa_in = 8'h3C, pb_in = 8'hA5;
  logic miso, miso_oe;
  logic [7:0] pa_out, pb_out, pa_oe, pb_oe, pa_pu, pb_pu;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_gpio_expander dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .strap(strap), .pa_in(pa_in), .pb_in(pb_in),
    .pa_out(pa_out), .pb_out(pb_out), .pa_oe(pa_oe), .pb_oe(pb_oe), .pa_pu(pa_pu), .pb_pu(pb_pu));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo(); wait_clk(2); cs_n = 1'b0; wait_clk(8); endtask
  task automatic cs_hi(); wait_clk(8); cs_n = 1'b1; wait_clk(8); endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      wait_clk(8);
      r[i] = miso;
      sck = 1'b1;
      wait_clk(8);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r;
    xbyte(b, r);
  endtask

  // driver for reads: pushes the expected byte, collected byte goes to monitor
  task automatic recv(input logic [7:0] exp, input string tag);
    logic [7:0] r;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xbyte(8'h00, r);
    got_q.push_back(r);
  endtask

  task automatic wr(input logic [7:0] ctrl, input logic [7:0] a, input logic [7:0] d);
    cs_lo(); send(ctrl); send(a); send(d); cs_hi();
  endtask

  task automatic rd1(input logic [7:0] ctrl, input logic [7:0] a, input logic [7:0] exp,
                     input string tag);
    cs_lo(); send(ctrl); send(a); recv(exp, tag); cs_hi();
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0)
        chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00);
    chk("R1 pa_pu", pa_pu, 8'h00);
    chk("R1 miso_oe", {7'd0, miso_oe}, 8'h00);

    // R3 strap field 000 ignored while address enable clear; R5 direction
    wr(8'h40, 8'h00, 8'h0F);
    chk("R5 pa_oe", pa_oe, 8'hF0);
    chk("R3 write accepted", pb_oe, 8'h00);

    // R8 port-value write loads latch
    wr(8'h4E, 8'h04, 8'h5A);
    chk("R8 pa_out", pa_out, 8'h5A);

    // R7 R11 mixed read
    rd1(8'h41, 8'h04, 8'h5C, "R7 R11 port A value");

    // R6 R9 burst write of pull-ups
    cs_lo(); send(8'h40); send(8'h02); send(8'hFF); send(8'h81); cs_hi();
    chk("R6 pa_pu", pa_pu, 8'hFF);
    chk("R6 R9 pb_pu", pb_pu, 8'h81);

    // R9 burst read across registers
    cs_lo(); send(8'h41); send(8'h00);
    recv(8'h0F, "R9 dir A"); recv(8'hFF, "R9 dir B"); recv(8'hFF, "R9 pu A");
    cs_hi();

    // R2 wrong device ID
    cs_lo(); send(8'h51); send(8'h00);
    wait_clk(4);
    chk("R2 miso_oe bad id", {7'd0, miso_oe}, 8'h00);
    cs_hi();
    wr(8'h50, 8'h01, 8'h00);
    chk("R2 pb_oe unchanged", pb_oe, 8'h00);

    // R4 address enable
    wr(8'h40, 8'h08, 8'h08);
    rd1(8'h4B, 8'h08, 8'h08, "R4 cfg readback");
    wr(8'h44, 8'h01, 8'h00);
    chk("R4 mismatch ignored", pb_oe, 8'h00);
    cs_lo(); send(8'h45); send(8'h00);
    wait_clk(4);
    chk("R4 mismatch no drive", {7'd0, miso_oe}, 8'h00);
    cs_hi();
    wr(8'h4A, 8'h01, 8'h00);
    chk("R4 match accepted", pb_oe, 8'hFF);
    rd1(8'h4B, 8'h05, 8'h00, "R4 R7 port B all outputs");

    // R12 unmapped address
    wr(8'h4A, 8'h20, 8'h77);
    rd1(8'h4B, 8'h20, 8'h00, "R12 unmapped read");
    chk("R12 latch unchanged", pa_out, 8'h5A);

    // R10 partial byte dropped
    cs_lo(); send(8'h4A); send(8'h06);
    for (int i = 0; i < 4; i++) begin
      mosi = 1'b1; wait_clk(8); sck = 1'b1; wait_clk(8); sck = 1'b0;
    end
    cs_hi();
    chk("R10 latch unchanged", pa_out, 8'h5A);
    wait_clk(2);
    chk("R10 miso released", {7'd0, miso_oe}, 8'h00);
    rd1(8'h4B, 8'h06, 8'h5A, "R10 fresh access");

    wait_clk(20);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule